// File: doc/BRIEF.md
# Asynchronous Memory Bank-Enable Decoder

This block is the control-register front end of an external asynchronous memory port. It keeps three registers behind a small memory-mapped register bus. The first is a 16-bit global control word. The other two are 32-bit bank-timing words, which the block stores but does not interpret. The block also rejects accesses to offsets that hold no register, and accesses of the wrong width to the global word.

Three bits of the global word give the number of external banks that are switched on. The external address space is split into four banks of equal, parameterised size that follow one another from an aligned region base. Banks are switched on as a prefix starting at bank 0. The memory-side decoder turns each address into a one-hot bank select. When the address lies in a switched-off bank, or outside the region, it raises a miss flag instead.

Top module: `amem_bank_ctrl`

## Requirements
- R1: After reset the global word reads 0x00F2 (parameter `GCTL_RST`). Both bank-timing words read 0xFFC2FFC2 when `PAIR_BANKS`=1 and 0x0000FFC2 when `PAIR_BANKS`=0.
- R2: The enabled-bank count is global bits [3:1] saturated at 4. Bank i is enabled exactly when i < count.
- R3: With `mem_valid` high and the address inside enabled bank i, `bank_sel` is the one-hot value 1<<i. Bank i covers `REGION_BASE` + i·2^`BANK_BITS` up to the next bank.
- R4: With `mem_valid` high, `mem_miss` is 1 exactly when `bank_sel` is zero: a disabled bank, or outside the 4-bank region. With `mem_valid` low, both outputs are zero.
- R5: The global word lives at byte offset 0x0 and accepts only `reg_size`=1 (2 bytes). Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=reserved. Any other size gives `reg_err`, leaves the register unchanged and returns read data 0.
- R6: The bank-timing words live at offsets 0x4 and 0x8. A write of any size stores all 32 bits of `reg_wdata`, and a read returns the stored value.
- R7: An access to any other offset (not 0x0, 0x4 or 0x8) gives `reg_err`, returns read data 0 and changes no register.
- R8: `reg_rdata` and `reg_err` are registered. They appear in the cycle after the clock edge that samples the request. `reg_err` is a one-cycle pulse and is low when no failing request was sampled.
- R9: A read of the global word returns all 16 written bits, including the reserved ones, zero-extended to 32 bits. A write to it changes the bank decode from the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register request strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW | Register byte offset |
| reg_size | input | 2 | Access size code |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| reg_err | output | 1 | Access error, one cycle after the request |
| mem_valid | input | 1 | Memory address valid |
| mem_addr | input | ADDR_W | Memory address |
| bank_sel | output | 4 | One-hot bank select |
| mem_miss | output | 1 | Address valid but no enabled bank hit |

## Verification
The bench builds the block with a 12-bit memory address, 16-byte banks (`BANK_BITS`=4) and a region base of 0x100. With these values the whole address space can be swept for every one of the eight enable-field values, including the saturating values 5 to 7. A second instance with `PAIR_BANKS`=0 brings the single-bank reset value within reach. The 4-bit register offset is swept in full with every size code, for both reads and writes.

// File: rtl/amem_pkg.sv
`timescale 1ns/1ps
package amem_pkg;
    localparam int NBANK   = 4;
    localparam int CNT_W   = 3;
    localparam int ENF_LSB = 1;

    localparam int OFF_GCTL  = 0;
    localparam int OFF_BCTL0 = 4;
    localparam int OFF_BCTL1 = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } amem_size_e;

    typedef struct packed {
        logic [15:0] gctl;
        logic [31:0] bctl0;
        logic [31:0] bctl1;
        logic [31:0] rdata;
        logic        err;
    } amem_regs_t;
endpackage

// File: rtl/amem_regfile.sv
`timescale 1ns/1ps
module amem_regfile
    import amem_pkg::*;
#(
    parameter int          REG_AW   = 4,
    parameter logic [15:0] GCTL_RST = 16'h00F2,
    parameter logic [31:0] BCTL_RST = 32'hFFC2FFC2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_err,
    output logic [CNT_W-1:0]  en_fld
);
    amem_regs_t regs_d, regs_q;

    logic hit_g, hit_b0, hit_b1, bad_off, bad_width;

    always_comb begin
        hit_g     = (reg_addr == REG_AW'(OFF_GCTL));
        hit_b0    = (reg_addr == REG_AW'(OFF_BCTL0));
        hit_b1    = (reg_addr == REG_AW'(OFF_BCTL1));
        bad_off   = !(hit_g || hit_b0 || hit_b1);
        bad_width = hit_g && (amem_size_e'(reg_size) != SZ_HALF);

        regs_d     = regs_q;
        regs_d.err = 1'b0;
        if (reg_valid) begin
            regs_d.err = bad_off || bad_width;
            if (reg_we) begin
                if (hit_g && !bad_width) regs_d.gctl  = reg_wdata[15:0];
                if (hit_b0)              regs_d.bctl0 = reg_wdata;
                if (hit_b1)              regs_d.bctl1 = reg_wdata;
            end else begin
                if (hit_g && !bad_width) regs_d.rdata = {16'h0000, regs_q.gctl};
                else if (hit_b0)         regs_d.rdata = regs_q.bctl0;
                else if (hit_b1)         regs_d.rdata = regs_q.bctl1;
                else                     regs_d.rdata = 32'h0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.gctl  <= GCTL_RST;
            regs_q.bctl0 <= BCTL_RST;
            regs_q.bctl1 <= BCTL_RST;
            regs_q.rdata <= 32'h0;
            regs_q.err   <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign reg_rdata = regs_q.rdata;
    assign reg_err   = regs_q.err;
    assign en_fld    = regs_q.gctl[ENF_LSB +: CNT_W];
endmodule

// File: rtl/amem_bank_count.sv
`timescale 1ns/1ps
module amem_bank_count
    import amem_pkg::*;
(
    input  logic [CNT_W-1:0] en_fld,
    output logic [NBANK-1:0] bank_en
);
    logic [CNT_W-1:0] cnt;

    always_comb begin
        cnt = (en_fld > CNT_W'(NBANK)) ? CNT_W'(NBANK) : en_fld;
    end

    for (genvar gi = 0; gi < NBANK; gi++) begin : g_en
        assign bank_en[gi] = (CNT_W'(gi) < cnt);
    end
endmodule

// File: rtl/amem_bank_decode.sv
`timescale 1ns/1ps
module amem_bank_decode
    import amem_pkg::*;
#(
    parameter int                 ADDR_W      = 32,
    parameter int                 BANK_BITS   = 20,
    parameter logic [ADDR_W-1:0]  REGION_BASE = '0
) (
    input  logic                    mem_valid,
    input  logic [ADDR_W-1:BANK_BITS] mem_page,
    input  logic [NBANK-1:0]        bank_en,
    output logic [NBANK-1:0]        bank_sel,
    output logic                    mem_miss
);
    localparam int IDX_W   = $clog2(NBANK);
    localparam int TAG_LSB = BANK_BITS + IDX_W;

    logic             in_region;
    logic [IDX_W-1:0] idx;

    always_comb begin
        in_region = (mem_page[ADDR_W-1:TAG_LSB] == REGION_BASE[ADDR_W-1:TAG_LSB]);
        idx       = mem_page[TAG_LSB-1:BANK_BITS];
    end

    for (genvar gi = 0; gi < NBANK; gi++) begin : g_sel
        assign bank_sel[gi] = mem_valid && in_region && (idx == IDX_W'(gi)) && bank_en[gi];
    end

    assign mem_miss = mem_valid && (bank_sel == '0);
endmodule

// File: rtl/amem_bank_ctrl.sv
`timescale 1ns/1ps
module amem_bank_ctrl
    import amem_pkg::*;
#(
    parameter int                REG_AW      = 4,
    parameter int                ADDR_W      = 32,
    parameter int                BANK_BITS   = 20,
    parameter logic [ADDR_W-1:0] REGION_BASE = ADDR_W'(32'h2000_0000),
    parameter bit                PAIR_BANKS  = 1'b1,
    parameter logic [15:0]       GCTL_RST    = 16'h00F2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_err,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        bank_sel,
    output logic              mem_miss
);
    localparam logic [31:0] BCTL_RST = PAIR_BANKS ? 32'hFFC2FFC2 : 32'h0000FFC2;

    logic [CNT_W-1:0] en_fld;
    logic [NBANK-1:0] bank_en;
    logic             unused_lo;

    assign unused_lo = ^mem_addr[BANK_BITS-1:0];

    amem_regfile #(
        .REG_AW  (REG_AW),
        .GCTL_RST(GCTL_RST),
        .BCTL_RST(BCTL_RST)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_valid(reg_valid),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_size (reg_size),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .reg_err  (reg_err),
        .en_fld   (en_fld)
    );

    amem_bank_count cnt_i (
        .en_fld (en_fld),
        .bank_en(bank_en)
    );

    amem_bank_decode #(
        .ADDR_W     (ADDR_W),
        .BANK_BITS  (BANK_BITS),
        .REGION_BASE(REGION_BASE)
    ) dec_i (
        .mem_valid(mem_valid),
        .mem_page (mem_addr[ADDR_W-1:BANK_BITS]),
        .bank_en  (bank_en),
        .bank_sel (bank_sel),
        .mem_miss (mem_miss)
    );
endmodule

// File: rtl/amem_bank_ctrl_chk.sv
`timescale 1ns/1ps
module amem_bank_ctrl_chk
    import amem_pkg::*;
#(
    parameter int REG_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_valid,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [1:0]        reg_size,
    input logic              reg_err,
    input logic              mem_valid,
    input logic [3:0]        bank_sel,
    input logic              mem_miss,
    input logic [CNT_W-1:0]  en_fld
);
    logic [CNT_W-1:0] lim;
    logic [3:0]       allowed;
    logic             off_ok;

    always_comb begin
        lim = (en_fld > CNT_W'(NBANK)) ? CNT_W'(NBANK) : en_fld;
        for (int i = 0; i < 4; i++) allowed[i] = (i < int'(lim));
        off_ok = (reg_addr == REG_AW'(0)) || (reg_addr == REG_AW'(4)) || (reg_addr == REG_AW'(8));
    end

    // R3
    onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bank_sel));
    // R2
    prefix_only_chk: assert property (@(posedge clk) disable iff (!rst_n) (bank_sel & ~allowed) == 4'b0);
    // R4
    sel_xor_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ((bank_sel != 4'b0) != mem_miss));
    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid |-> (bank_sel == 4'b0 && !mem_miss));
    // R7
    bad_off_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !off_ok) |=> reg_err);
    // R7
    bad_off_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_we && !off_ok) |=> $stable(en_fld));
    // R5
    width_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_addr == REG_AW'(0) && reg_size != 2'd1) |=> (reg_err && $stable(en_fld)));
    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $past(reg_valid));
endmodule

bind amem_bank_ctrl amem_bank_ctrl_chk #(.REG_AW(REG_AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_valid(reg_valid),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_size (reg_size),
    .reg_err  (reg_err),
    .mem_valid(mem_valid),
    .bank_sel (bank_sel),
    .mem_miss (mem_miss),
    .en_fld   (en_fld)
);

// File: tb/amem_bank_ctrl_tb.sv
`timescale 1ns/1ps
module amem_bank_ctrl_tb_top;
    localparam int ADDR_W = 12;
    localparam int BANK_B = 4;
    localparam int BASE   = 'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [1:0]  reg_size = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, s_rdata;
    logic        reg_err, s_err;
    logic        mem_valid = 1'b0;
    logic [ADDR_W-1:0] mem_addr = '0;
    logic [3:0]  bank_sel, s_sel;
    logic        mem_miss, s_miss;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_gctl;
    logic [31:0] m_b0, m_b1;

    always #10 clk = ~clk;

    amem_bank_ctrl #(.REG_AW(4), .ADDR_W(ADDR_W), .BANK_BITS(BANK_B),
                     .REGION_BASE(12'h100), .PAIR_BANKS(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_err(reg_err), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .bank_sel(bank_sel), .mem_miss(mem_miss));

    amem_bank_ctrl #(.REG_AW(4), .ADDR_W(ADDR_W), .BANK_BITS(BANK_B),
                     .REGION_BASE(12'h100), .PAIR_BANKS(1'b0)) single_i (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(s_rdata), .reg_err(s_err), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .bank_sel(s_sel), .mem_miss(s_miss));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus(input logic we, input logic [3:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd, output logic er);
        @(negedge clk);
        reg_valid = 1'b1; reg_we = we; reg_addr = a; reg_size = sz; reg_wdata = wd;
        @(negedge clk);
        reg_valid = 1'b0; reg_we = 1'b0;
        rd = reg_rdata; er = reg_err;
    endtask

    function automatic logic [4:0] exp_dec(input int addr, input logic [15:0] g);
        int cnt;
        int idx;
        cnt = (g >> 1) & 7;
        if (cnt > 4) cnt = 4;
        if (addr >= BASE && addr < BASE + 4 * (1 << BANK_B)) begin
            idx = (addr - BASE) >> BANK_B;
            if (idx < cnt) return {4'(1 << idx), 1'b0};
        end
        return 5'b0_0001;
    endfunction

    task automatic check_regs(input string req);
        logic [31:0] rd; logic er;
        bus(1'b0, 4'h0, 2'd1, 32'h0, rd, er); chk(req, rd, {16'h0, m_gctl}); chk(req, 32'(er), 0);
        bus(1'b0, 4'h4, 2'd2, 32'h0, rd, er); chk(req, rd, m_b0);
        bus(1'b0, 4'h8, 2'd2, 32'h0, rd, er); chk(req, rd, m_b1);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        m_gctl = 16'h00F2; m_b0 = 32'hFFC2FFC2; m_b1 = 32'hFFC2FFC2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, both variants; R8 error low at reset
        chk("R1", 32'(reg_err), 0);
        bus(1'b0, 4'h4, 2'd2, 32'h0, rd, er);
        chk("R1", s_rdata, 32'h0000FFC2);
        bus(1'b0, 4'h8, 2'd2, 32'h0, rd, er);
        chk("R1", s_rdata, 32'h0000FFC2);
        check_regs("R1");

        // R2 R3 R4: reset decode (field 1) swept over the whole space
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            mem_valid = 1'b1; mem_addr = ADDR_W'(a); #1;
            chk("R3", {27'h0, bank_sel, mem_miss}, {27'h0, exp_dec(a, m_gctl)});
        end

        // R2 R3 R4 R9: every enable field value, reserved bits kept
        for (int f = 0; f < 8; f++) begin
            logic [15:0] v;
            v = {12'hA5C, 3'(f), 1'b1};
            bus(1'b1, 4'h0, 2'd1, {16'hFFFF, v}, rd, er);
            m_gctl = v;
            chk("R9", 32'(er), 0);
            // R9 decode already follows the new field in this cycle
            mem_addr = ADDR_W'(BASE + 3 * 16); #1;
            chk("R9", {31'h0, mem_miss}, {31'h0, (f < 4)});
            bus(1'b0, 4'h0, 2'd1, 32'h0, rd, er);
            chk("R9", rd, {16'h0, v});
            for (int a = 0; a < (1 << ADDR_W); a++) begin
                mem_addr = ADDR_W'(a); #1;
                chk("R2", {27'h0, bank_sel, mem_miss}, {27'h0, exp_dec(a, m_gctl)});
            end
        end

        // R4 idle: no select, no miss
        for (int a = BASE; a < BASE + 64; a += 8) begin
            mem_valid = 1'b0; mem_addr = ADDR_W'(a); #1;
            chk("R4", {27'h0, bank_sel, mem_miss}, 32'h0);
        end

        // R5 width of global word
        for (int s = 0; s < 4; s++) begin
            bus(1'b0, 4'h0, 2'(s), 32'h0, rd, er);
            chk("R5", 32'(er), (s != 1) ? 1 : 0);
            chk("R5", rd, (s == 1) ? {16'h0, m_gctl} : 32'h0);
            // R8 error pulse lasts one cycle
            @(negedge clk); chk("R8", 32'(reg_err), 0);
            bus(1'b1, 4'h0, 2'(s), 32'h0000_3333 + 32'(s), rd, er);
            if (s == 1) m_gctl = 16'h3334;
            chk("R5", 32'(er), (s != 1) ? 1 : 0);
            check_regs("R5");
        end

        // R6 bank-timing words take full 32 bits at any size
        bus(1'b1, 4'h4, 2'd0, 32'h12345678, rd, er); m_b0 = 32'h12345678;
        chk("R6", 32'(er), 0);
        bus(1'b1, 4'h8, 2'd2, 32'h9ABCDEF0, rd, er); m_b1 = 32'h9ABCDEF0;
        chk("R6", 32'(er), 0);
        check_regs("R6");

        // R7 every offset and size, reads and writes
        for (int o = 0; o < 16; o++) begin
            for (int s = 0; s < 4; s++) begin
                logic ok;
                logic [31:0] exp_rd;
                ok = (o == 4) || (o == 8) || (o == 0 && s == 1);
                bus(1'b0, 4'(o), 2'(s), 32'h0, rd, er);
                exp_rd = (o == 0 && s == 1) ? {16'h0, m_gctl} : (o == 4) ? m_b0 : (o == 8) ? m_b1 : 32'h0;
                chk("R7", 32'(er), ok ? 0 : 1);
                chk("R7", rd, exp_rd);
                if (!ok || o == 4) begin
                    bus(1'b1, 4'(o), 2'(s), 32'hDEAD0000 + 32'(o * 4 + s), rd, er);
                    if (o == 4) m_b0 = 32'hDEAD0000 + 32'(o * 4 + s);
                    chk("R7", 32'(er), ok ? 0 : 1);
                end
            end
            check_regs("R7");
        end

        finish_run();
    end
endmodule